// File: doc/BRIEF.md
# Three-Channel Encoder Input Debounce Filter

This block cleans up the three digital signals that come from an incremental encoder: the two phase lines and the index line. None of them is synchronous to the system clock. Each line first passes through a two-flop synchronizer. A per-channel stability filter then sets the channel's clean level. The stability filters all sample on one shared sample tick. That tick comes from the system clock through a programmable divider, whose ratio is picked by a 3-bit select code.

A channel's clean level moves to a new value only after the synchronized input has shown that value on three sample ticks in a row. A tick that shows the old level clears the run, so a spike or burst lasting up to two sample periods never reaches the output. The filters keep running at all times. A registered enable chooses what drives the outputs. When it is high, the outputs carry the filtered levels. When it is low, they carry the synchronized raw levels. The enable register clears on reset, so the block comes up in pass-through.

Top module: `enc_input_filter`

## Requirements
- R1: While rst_n is low, all outputs are 0 and the enable register is cleared. Reset is asynchronous, so the outputs fall to 0 without waiting for a clock edge.
- R2: With the enable register low, each output equals its raw input as it was three rising clock edges earlier: two synchronizer stages plus the output register.
- R3: A filtered level changes only on a sample tick, and only after three consecutive ticks saw the new level. With select code 000, a raw change reaches the output on exactly the sixth rising edge after the change.
- R4: A sample that matches the current filtered level restarts that channel's count. Pulses lasting at most two sample periods, and broken runs such as 1,1,0,1,1, leave the filtered level unchanged.
- R5: The select code sets the sample tick period in clock cycles: 000=1, 001=2, 010=4, 011=8, 100=16, 101=32, 110=64, 111=256.
- R6: The channels are independent. Bit 0 is phase A, bit 1 is phase B and bit 2 is the index.
- R7: The filt_en input is registered. Its stored value picks filtered (1) or synchronized raw (0) for the output register, with one clock of delay.
- R8: The filters keep tracking while the outputs are in pass-through. Turning the enable on therefore shows the level the filter has already settled to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | 1 = drive filtered levels, 0 = drive synchronized raw levels |
| div_sel | input | 3 | Sample tick divide select code |
| raw_in | input | 3 | Asynchronous inputs: {index, phase B, phase A} |
| filt_out | output | 3 | Registered output levels, same bit order as raw_in |

## Verification
In pass-through, a raw change is due at the output on the third rising edge. In filter mode at ratio 1, it is due on the sixth edge. The bench checks one edge early and again exactly on the due edge, and samples on the falling edge. At larger ratios, the phase of the sample tick is not visible at the ports. Those vectors therefore use windows that have a fixed outcome whatever the phase. A pulse of two tick periods can never span three ticks, so it must be rejected. A hold of four periods plus the pipeline delay must always be accepted. The checker times the tick spacing itself with a counter, and checks the three-edge pass-through delay against a count of edges since reset.

// File: rtl/enc_filt_pkg.sv
package enc_filt_pkg;
  localparam int unsigned DIV_SEL_W = 3;
  localparam int unsigned MAX_RATIO = 256;
  localparam int unsigned DIV_CNT_W = $clog2(MAX_RATIO);

  // Sample-tick period in clock cycles for a select code.
  function automatic int unsigned div_ratio(input logic [DIV_SEL_W-1:0] code);
    if (code == '1) return MAX_RATIO;
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/efilt_tick_gen.sv
module efilt_tick_gen
  import enc_filt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic [DIV_CNT_W-1:0] limit;

  assign limit = DIV_CNT_W'(div_ratio(div_sel) - 1);
  // ">=" lets a shrinking ratio wrap at once instead of running to overflow.
  assign tick  = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/efilt_sync.sv
module efilt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/efilt_stable_cell.sv
module efilt_stable_cell #(
  parameter int unsigned STABLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic smp,
  output logic level
);
  localparam int unsigned RUN_W = (STABLE_TICKS > 2) ? $clog2(STABLE_TICKS) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_TICKS - 1);

  logic [RUN_W-1:0] run_q;
  logic             level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (tick) begin
      if (smp == level_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        level_q <= smp;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level = level_q;
endmodule

// File: rtl/enc_input_filter.sv
module enc_input_filter
  import enc_filt_pkg::*;
#(
  parameter int unsigned NUM_CH       = 3,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STABLE_TICKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 filt_en,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic [NUM_CH-1:0]    raw_in,
  output logic [NUM_CH-1:0]    filt_out
);
  logic              tick;
  logic [NUM_CH-1:0] sync_q;
  logic [NUM_CH-1:0] filt_q;
  logic [NUM_CH-1:0] out_q;
  logic              en_q;

  efilt_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .tick    (tick)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    efilt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in[ch]),
      .q     (sync_q[ch])
    );
    efilt_stable_cell #(.STABLE_TICKS(STABLE_TICKS)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .smp   (sync_q[ch]),
      .level (filt_q[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      out_q <= '0;
    end else begin
      en_q  <= filt_en;
      out_q <= en_q ? filt_q : sync_q;
    end
  end

  assign filt_out = out_q;
endmodule

// File: rtl/enc_input_filter_chk.sv
module enc_input_filter_chk
  import enc_filt_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DIV_SEL_W-1:0] div_sel,
  input logic [NUM_CH-1:0]    raw_in,
  input logic [NUM_CH-1:0]    filt_out,
  input logic                 tick,
  input logic [NUM_CH-1:0]    sync_q,
  input logic [NUM_CH-1:0]    filt_q,
  input logic                 en_q
);
  logic [1:0]           edges_q;
  logic [DIV_CNT_W+1:0] gap_q;
  logic                 gap_ok_q;
  logic [DIV_SEL_W-1:0] sel_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q    <= '0;
      gap_q      <= '0;
      gap_ok_q   <= 1'b0;
      sel_prev_q <= '0;
    end else begin
      if (edges_q != 2'd3) edges_q <= edges_q + 1'b1;
      sel_prev_q <= div_sel;
      gap_q      <= tick ? '0 : gap_q + 1'b1;
      if (div_sel != sel_prev_q) gap_ok_q <= 1'b0;
      else if (tick)             gap_ok_q <= 1'b1;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) rst_out_zero_chk: assert (filt_out == '0 && !en_q);
  end

  // R2
  bypass_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == 2'd3 && !$past(en_q)) |-> filt_out == $past(raw_in, 3));

  // R3
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> $past(tick));

  // R4
  change_to_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ((filt_q ^ $past(filt_q)) & (filt_q ^ $past(sync_q))) == '0);

  // R5
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gap_ok_q && div_sel == sel_prev_q) |-> (32'(gap_q) + 1 == div_ratio(div_sel)));
endmodule

bind enc_input_filter enc_input_filter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .div_sel  (div_sel),
  .raw_in   (raw_in),
  .filt_out (filt_out),
  .tick     (tick),
  .sync_q   (sync_q),
  .filt_q   (filt_q),
  .en_q     (en_q)
);

// File: tb/enc_input_filter_tb.sv
module enc_input_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       filt_en = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [2:0] raw_in = 3'd0;
  logic [2:0] filt_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  enc_input_filter u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .filt_en  (filt_en),
    .div_sel  (div_sel),
    .raw_in   (raw_in),
    .filt_out (filt_out)
  );

  // {req[3:0], div_sel[2:0], en, raw[2:0], hold[11:0], expected[2:0]}
  localparam int NV = 24;
  localparam logic [25:0] VEC [NV] = '{
    {4'd3, 3'd0, 1'b1, 3'd0, 12'd5,    3'd7}, // R3 one edge early
    {4'd3, 3'd0, 1'b1, 3'd0, 12'd1,    3'd0}, // R3 sixth edge
    {4'd4, 3'd0, 1'b1, 3'd5, 12'd2,    3'd0}, // R4 two-tick pulse
    {4'd4, 3'd0, 1'b1, 3'd0, 12'd10,   3'd0}, // R4 pulse rejected
    {4'd4, 3'd0, 1'b1, 3'd5, 12'd2,    3'd0}, // R4 broken run part 1
    {4'd4, 3'd0, 1'b1, 3'd0, 12'd1,    3'd0}, // R4 gap restarts count
    {4'd4, 3'd0, 1'b1, 3'd5, 12'd2,    3'd0}, // R4 broken run part 2
    {4'd4, 3'd0, 1'b1, 3'd0, 12'd10,   3'd0}, // R4 broken run rejected
    {4'd6, 3'd0, 1'b1, 3'd2, 12'd12,   3'd2}, // R6 phase B alone
    {4'd7, 3'd0, 1'b0, 3'd2, 12'd2,    3'd2}, // R7 switch to pass-through
    {4'd2, 3'd0, 1'b0, 3'd4, 12'd2,    3'd2}, // R2 two edges: not yet
    {4'd2, 3'd0, 1'b0, 3'd4, 12'd1,    3'd4}, // R2 third edge
    {4'd2, 3'd0, 1'b0, 3'd1, 12'd12,   3'd1}, // R2 phase A alone
    {4'd8, 3'd0, 1'b1, 3'd1, 12'd2,    3'd1}, // R8 filter already settled
    {4'd5, 3'd4, 1'b1, 3'd6, 12'd32,   3'd1}, // R5 ratio 16, pulse of 2 periods
    {4'd5, 3'd4, 1'b1, 3'd1, 12'd80,   3'd1}, // R5 rejected
    {4'd5, 3'd4, 1'b1, 3'd6, 12'd72,   3'd6}, // R5 ratio 16 accepted
    {4'd5, 3'd6, 1'b1, 3'd1, 12'd264,  3'd1}, // R5 ratio 64 accepted
    {4'd5, 3'd7, 1'b1, 3'd6, 12'd512,  3'd1}, // R5 ratio 256, pulse of 2 periods
    {4'd5, 3'd7, 1'b1, 3'd1, 12'd1100, 3'd1}, // R5 rejected (a 128 ratio would pass)
    {4'd5, 3'd7, 1'b1, 3'd6, 12'd1032, 3'd6}, // R5 ratio 256 accepted
    {4'd5, 3'd1, 1'b1, 3'd3, 12'd4,    3'd6}, // R5 ratio 2, pulse of 2 periods
    {4'd5, 3'd1, 1'b1, 3'd6, 12'd20,   3'd6}, // R5 rejected
    {4'd5, 3'd1, 1'b1, 3'd3, 12'd20,   3'd3}  // R5 ratio 2 accepted
  };

  task automatic check(input int req, input logic [2:0] exp);
    checks++;
    if (filt_out !== exp) begin
      fails++;
      $display("FAIL R%0d: filt_out=%b expected %b at %0t", req, filt_out, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs low even with inputs high and enable set
    filt_en = 1'b1;
    raw_in  = 3'd7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 3'd0);
    rst_n = 1'b1;
    check(1, 3'd0);
    // R3: filtered level due on the sixth edge after release
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(3, 3'd0);
    @(posedge clk);
    @(negedge clk);
    check(3, 3'd7);

    for (int i = 0; i < NV; i++) begin
      div_sel = VEC[i][21:19];
      filt_en = VEC[i][18];
      raw_in  = VEC[i][17:15];
      repeat (int'(VEC[i][14:3])) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][25:22]), VEC[i][2:0]);
    end

    // R1: asynchronous clear in mid-run
    rst_n = 1'b0;
    #1;
    check(1, 3'd0);
    @(negedge clk);
    // R7: enable register cleared, so pass-through after release
    filt_en = 1'b0;
    div_sel = 3'd7;
    raw_in  = 3'd5;
    rst_n   = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(7, 3'd5);

    finish_run();
  end
endmodule